// File: doc/BRIEF.md
# Multichannel Register-Programmed PWM Generator

This block drives up to four independent pulse-width-modulated outputs. Each channel has one 32-bit control word on a plain read/write bus. The word holds four settings: a clock divider, an 8-bit pulse width, a force-full-duty flag and a run flag. Inside each channel, a prescaler slows the system clock. An 8-bit phase counter then advances once per prescaler tick. The output is high while the phase is below the pulse width, so one waveform period always spans 256 phase steps.

Software changes a channel by writing its whole control word. Every write restarts that channel's waveform from the beginning of a period with the new settings, and the current period is not completed. Clearing the run flag drops the output on the next clock.

Top module: `pwm_bank`

## Requirements
- R1: After a synchronous active-low reset, every control word reads zero and every output is low.
- R2: Channel n's control word sits at byte address n*16, with address bits [3:0] zero. A write to any other address is ignored, and a read from any other address returns zero.
- R3: Reads return the stored word. Only bits 31 (run), 24 (full duty), 23:16 (pulse width) and 12:0 (divider) are stored. All other bits read as zero, whatever value was written to them.
- R4: Each phase step lasts divider+1 clocks, so one period lasts 256*(divider+1) clocks. A divider of 0 gives one step per clock.
- R5: The output is active-high. While the channel runs, the output is high for the first width*(divider+1) clocks of each period and low for the rest. A width of 0 keeps the output low for the whole period.
- R6: When bit 24 is set, a running channel's output stays high for the whole period and the pulse-width field has no effect.
- R7: Writing a word with bit 31 clear forces the output low from the next clock, even in mid-period, and the output stays low.
- R8: A write to a running channel abandons the current period. The new settings take effect from the next clock, starting at phase zero.
- R9: A write to one channel leaves the waveform of every other channel undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, together with bus_sel |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH (4) | Per-channel PWM outputs |

## Verification
The hardest case to reach from the ports is a rewrite or a disable that lands in the middle of a period. The stimulus first lets a channel run a known number of clocks into its high phase, then writes the channel again. The bench then counts high clocks over one full period that starts at that write. This count separates an immediate restart from one that waits for the period to end. A second case writes a neighbouring channel while a channel is being measured, so that any disturbance between channels shows up in the measured count.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;

   localparam int WORD_W     = 32;
   localparam int RUN_BIT    = 31;
   localparam int FULL_BIT   = 24;
   localparam int WIDTH_LSB  = 16;
   localparam int WIDTH_W    = 8;
   localparam int DIV_LSB    = 0;
   localparam int DIV_W      = 13;
   localparam int STRIDE_LSB = 4;
   localparam int MAX_CH     = 4;

   localparam logic [WORD_W-1:0] STORE_MASK = 32'h81FF_1FFF;

   typedef struct packed {
      logic               run;
      logic               full;
      logic [WIDTH_W-1:0] width;
      logic [DIV_W-1:0]   div;
   } chan_cfg_t;

   function automatic chan_cfg_t decode_word(input logic [WORD_W-1:0] w);
      chan_cfg_t c;
      c.run   = w[RUN_BIT];
      c.full  = w[FULL_BIT];
      c.width = w[WIDTH_LSB +: WIDTH_W];
      c.div   = w[DIV_LSB +: DIV_W];
      return c;
   endfunction

endpackage

// File: rtl/pwm_ctl_reg.sv
module pwm_ctl_reg
   import pwmgen_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] word_q,
   output chan_cfg_t         cfg
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         word_q <= '0;
      else if (wr)
         word_q <= wdata & STORE_MASK;
   end

   assign cfg = decode_word(word_q);

   // R3: a write stores exactly the implemented bits
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (word_q == ($past(wdata) & STORE_MASK)));

   // R3: with no write the word holds
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(word_q));

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int DW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          restart,
   input  logic [DW-1:0] div,
   output logic          tick
);

   logic [DW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || restart || !run)
         cnt <= '0;
      else if (cnt == div)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == div);

   // R4: the count never passes the divider while running
   a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart) |-> (cnt <= div));

   // R4: counting up one per clock until the terminal value
   a_r4_count: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart && !tick) |=> (cnt == $past(cnt) + 1'b1));

   // R8: a restart clears the prescaler
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));

endmodule

// File: rtl/pwm_phase.sv
module pwm_phase #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          restart,
   input  logic          tick,
   input  logic          full,
   input  logic [PW-1:0] width,
   output logic          pwm
);

   logic [PW-1:0] phase;

   always_ff @(posedge clk) begin
      if (!rst_n || restart || !run)
         phase <= '0;
      else if (tick)
         phase <= phase + 1'b1;
   end

   assign pwm = run && (full || (phase < width));

   // R4: each tick advances the phase by one, wrapping after 2**PW
   a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !restart) |=> (phase == $past(phase) + 1'b1));

   // R8: a restart returns the phase to the start of a period
   a_r8_phase0: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase == '0));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwmgen_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int IDX_W = ADDR_W - STRIDE_LSB;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("pwm_bank: NUM_CH must lie in 1..4");
   end
   if (IDX_W < 1 || (1 << IDX_W) < NUM_CH) begin : g_bad_addr
      $error("pwm_bank: ADDR_W too narrow for NUM_CH");
   end

   logic              off_ok;
   logic [IDX_W-1:0]  idx;
   logic [NUM_CH-1:0] hit;
   logic [NUM_CH-1:0] wr;
   logic [31:0]       word_q [NUM_CH];

   assign off_ok = (bus_addr[STRIDE_LSB-1:0] == '0);
   assign idx    = bus_addr[ADDR_W-1:STRIDE_LSB];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      chan_cfg_t cfg;
      logic      tick;

      assign hit[c] = off_ok && (idx == IDX_W'(c));
      assign wr[c]  = bus_sel && bus_we && hit[c];

      pwm_ctl_reg u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr     (wr[c]),
         .wdata  (bus_wdata),
         .word_q (word_q[c]),
         .cfg    (cfg)
      );

      pwm_prescale #(.DW(DIV_W)) u_pre (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (cfg.run),
         .restart (wr[c]),
         .div     (cfg.div),
         .tick    (tick)
      );

      pwm_phase #(.PW(WIDTH_W)) u_ph (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (cfg.run),
         .restart (wr[c]),
         .tick    (tick),
         .full    (cfg.full),
         .width   (cfg.width),
         .pwm     (pwm_out[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (hit[c]) bus_rdata = bus_rdata | word_q[c];
   end

   // R2: at most one channel decodes any address
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   pwm_bank #(.NUM_CH(4), .ADDR_W(8)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   localparam int NV = 6;
   localparam int VCH   [NV] = '{0, 1, 2, 3, 0, 2};
   localparam int VDIV  [NV] = '{0, 2, 0, 1, 0, 3};
   localparam int VWID  [NV] = '{64, 10, 0, 255, 128, 1};
   localparam int VFULL [NV] = '{0, 0, 0, 0, 1, 0};
   localparam int VHIGH [NV] = '{64, 30, 0, 510, 256, 4};

   function automatic logic [31:0] mk(input bit run, input bit full,
                                      input int width, input int div);
      return {run, 6'b0, full, width[7:0], 3'b0, div[12:0]};
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic count_high(input int ch, input int n, output int h);
      h = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out[ch]) h++;
      end
   endtask

   initial begin
      int watch = 0;
      while (!done && watch < 190000) begin
         @(posedge clk);
         watch++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int h;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      for (int c = 0; c < 4; c++) begin
         bus_rd(8'(c * 16), rd);
         check("R1 word", rd, 0);
      end
      check("R1 outputs", pwm_out, 0);

      // table of waveform vectors: R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         int per;
         int first;
         per = 256 * (VDIV[v] + 1);
         first = (VWID[v] > 0 || VFULL[v] != 0) ? 1 : 0;
         bus_wr(8'(VCH[v] * 16), mk(1'b1, VFULL[v][0], VWID[v], VDIV[v]));
         @(negedge clk);
         check("R5 first clock level", pwm_out[VCH[v]], first);
         count_high(VCH[v], per - 1, h);
         check("R5 R6 high clocks per period", h + first, VHIGH[v]);
         @(negedge clk);
         check("R4 next period restarts", pwm_out[VCH[v]], first);
         bus_wr(8'(VCH[v] * 16), 32'h0);
      end

      // R3: unimplemented bits read zero
      bus_wr(8'h10, 32'hFFFF_FFFF);
      bus_rd(8'h10, rd);
      check("R3 mask", rd, 32'h81FF_1FFF);
      bus_wr(8'h10, 32'h7E00_E000);
      bus_rd(8'h10, rd);
      check("R3 only unused bits", rd, 0);

      // R2: misaligned and out-of-range addresses
      bus_wr(8'h20, 32'h0000_0005);
      bus_wr(8'h24, 32'hFFFF_FFFF);
      bus_rd(8'h20, rd);
      check("R2 misaligned write ignored", rd, 32'h5);
      bus_rd(8'h24, rd);
      check("R2 misaligned read zero", rd, 0);
      bus_wr(8'h40, 32'hFFFF_FFFF);
      bus_rd(8'h40, rd);
      check("R2 out of range read zero", rd, 0);
      bus_wr(8'h20, 32'h0);

      // R7: disable mid-period
      bus_wr(8'h00, mk(1'b1, 1'b0, 200, 0));
      count_high(0, 10, h);
      check("R7 running before disable", h, 10);
      bus_wr(8'h00, mk(1'b0, 1'b0, 200, 0));
      @(negedge clk);
      check("R7 low next clock", pwm_out[0], 0);
      count_high(0, 300, h);
      check("R7 stays low", h, 0);

      // R8: rewrite mid-period restarts at once
      bus_wr(8'h00, mk(1'b1, 1'b0, 200, 0));
      count_high(0, 100, h);
      check("R8 high before rewrite", pwm_out[0], 1);
      bus_wr(8'h00, mk(1'b1, 1'b0, 50, 0));
      count_high(0, 256, h);
      check("R8 new width from phase zero", h, 50);
      bus_wr(8'h00, 32'h0);

      // R9: writing a neighbour leaves this channel alone
      bus_wr(8'h10, mk(1'b1, 1'b0, 100, 0));
      fork
         count_high(1, 256, h);
         begin
            repeat (50) @(posedge clk);
            bus_wr(8'h20, mk(1'b1, 1'b1, 3, 1));
         end
      join
      check("R9 channel 1 undisturbed", h, 100);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule